// File: doc/BRIEF.md
# Asynchronous Message List Sequencer

This block holds the list pointer of a bus controller's instruction sequencer. It also lets the host divert execution from the list it is running to a secondary list of asynchronous messages, then return. The host raises a request strobe, and the block then waits for the right moment to divert. If the controller is idle, it diverts on the next clock edge. If the controller is running a list, it diverts after the message in progress completes. At the switch, the current pointer goes into a one-entry save register and the pointer is loaded from the asynchronous base input.

While the secondary list runs, the block refuses two things: start instructions, and the servicing of further host requests. A request that arrives in that window is latched and serviced later. When the return instruction is decoded, the saved pointer is restored and the controller goes back to the state it had before the diversion, either running or idle. The start and request paths are enabled again at the same time. A return instruction decoded outside a diversion sets a sticky error flag and changes nothing else.

The pointer also follows the normal list. A start instruction loads it, an advance strobe steps it forward by `ADV_STEP`, and an end-of-list strobe sends the controller to idle.

Top module: `asl_seq`

## Requirements
- R1: While `rst_n` is low and on leaving reset, `list_ptr` is 0 and `busy`, `diverted`, `pending` and `ret_err` are 0, while `start_en` and `async_en` are 1.
- R2: When `start_dec` is high and the block is not diverted, then one cycle later `list_ptr` equals `start_ptr` and `busy` is 1.
- R3: When `ptr_adv` is high and `busy` is 1 and no other load happens that cycle, `list_ptr` grows by `ADV_STEP` (default 1) one cycle later. While idle, `ptr_adv` has no effect.
- R4: When `list_end` is high while running a normal (not diverted) list, `busy` is 0 one cycle later and `list_ptr` is kept.
- R5: When `host_req` is high while idle and not diverted, then one cycle later `diverted` and `busy` are 1 and `list_ptr` equals `async_base`.
- R6: When `host_req` is high while running a normal list, `pending` becomes 1 and no diversion happens until `msg_done` is high. One cycle after that `msg_done`, `diverted` is 1, `pending` is 0 and `list_ptr` equals `async_base`. An advance or start in the switch cycle is dropped.
- R7: At a switch, the current `list_ptr` is saved. One cycle after `ret_dec` while diverted, `list_ptr` equals the saved value, `diverted` is 0, and `busy` equals its value just before the switch.
- R8: While diverted, `start_en` and `async_en` are 0, and both `start_dec` and `list_end` are ignored. The return instruction sets both enables back to 1.
- R9: A `host_req` that arrives while diverted sets `pending` and is kept. After the return, it is serviced: on the next cycle if the restored state is idle, or after the next `msg_done` if the restored state is running.
- R10: `ret_dec` while not diverted sets `ret_err` one cycle later. `ret_err` stays 1 until reset, and `list_ptr` and `busy` are unchanged.
- R11: If `host_req` and `start_dec` are both high in one idle cycle, the diversion wins and the start is dropped. The later return therefore restores idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host asynchronous-list request strobe |
| async_base | input | PTR_W | Start address of the asynchronous list |
| msg_done | input | 1 | Current message complete strobe |
| ret_dec | input | 1 | Return-from-asynchronous instruction decoded |
| start_dec | input | 1 | Start instruction decoded |
| start_ptr | input | PTR_W | List address carried by the start instruction |
| ptr_adv | input | 1 | Step the pointer to the next instruction |
| list_end | input | 1 | End of the normal list reached |
| list_ptr | output | PTR_W | Current list pointer |
| busy | output | 1 | Controller is running a list |
| diverted | output | 1 | Asynchronous list in progress |
| pending | output | 1 | A host request waits for service |
| start_en | output | 1 | Start instruction is accepted |
| async_en | output | 1 | New requests may be serviced |
| ret_err | output | 1 | Sticky: return decoded outside a diversion |

## Verification
Every registered result (`list_ptr`, `busy`, `diverted`, `pending` and `ret_err`) is due exactly one clock edge after the strobe that causes it. The enables follow `diverted` within the same cycle. The bench drives each stimulus on the falling edge and samples 1 ns after the next rising edge. Each vector or directed step therefore compares against the state one edge later. Latency that depends on `msg_done`, as for a request held while running, is checked by holding the strobe away for a cycle and seeing no switch, then raising it and expecting the switch at the following edge.

// File: rtl/asl_pkg.sv
package asl_pkg;
   typedef enum logic [2:0] {
      OP_HOLD   = 3'd0,
      OP_DIVERT = 3'd1,
      OP_RETURN = 3'd2,
      OP_START  = 3'd3,
      OP_STOP   = 3'd4,
      OP_ADV    = 3'd5
   } seq_op_e;
endpackage

// File: rtl/asl_ctrl.sv
module asl_ctrl
   import asl_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    host_req,
   input  logic    msg_done,
   input  logic    ret_dec,
   input  logic    start_dec,
   input  logic    ptr_adv,
   input  logic    list_end,
   output seq_op_e op,
   output logic    busy_q,
   output logic    div_q,
   output logic    pend_q,
   output logic    err_q
);
   logic idle_ret_q;
   logic pend_eff;
   logic can_switch;

   assign pend_eff   = pend_q | host_req;
   assign can_switch = pend_eff & ~div_q & (~busy_q | msg_done);

   always_comb begin
      if (ret_dec && div_q)                   op = OP_RETURN;
      else if (can_switch)                    op = OP_DIVERT;
      else if (start_dec && !div_q)           op = OP_START;
      else if (list_end && busy_q && !div_q)  op = OP_STOP;
      else if (ptr_adv && busy_q)             op = OP_ADV;
      else                                    op = OP_HOLD;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         div_q      <= 1'b0;
         pend_q     <= 1'b0;
         err_q      <= 1'b0;
         idle_ret_q <= 1'b0;
      end else begin
         pend_q <= (op == OP_DIVERT) ? 1'b0 : pend_eff;
         if (ret_dec && !div_q) err_q <= 1'b1;
         unique case (op)
            OP_DIVERT: begin
               div_q      <= 1'b1;
               busy_q     <= 1'b1;
               idle_ret_q <= ~busy_q;
            end
            OP_RETURN: begin
               div_q  <= 1'b0;
               busy_q <= ~idle_ret_q;
            end
            OP_START: busy_q <= 1'b1;
            OP_STOP:  busy_q <= 1'b0;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/asl_stack.sv
module asl_stack #(
   parameter int PTR_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [PTR_W-1:0] push_val,
   output logic [PTR_W-1:0] top_val
);
   always_ff @(posedge clk) begin
      if (!rst_n)    top_val <= '0;
      else if (push) top_val <= push_val;
   end
endmodule

// File: rtl/asl_ptr.sv
module asl_ptr
   import asl_pkg::*;
#(
   parameter int PTR_W    = 16,
   parameter int ADV_STEP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  seq_op_e          op,
   input  logic [PTR_W-1:0] async_base,
   input  logic [PTR_W-1:0] saved_ptr,
   input  logic [PTR_W-1:0] start_ptr,
   output logic [PTR_W-1:0] ptr_q
);
   localparam logic [PTR_W-1:0] STEP_V = PTR_W'(ADV_STEP);
   logic [PTR_W-1:0] ptr_next_seq;

   generate
      if (ADV_STEP == 1) begin : g_inc
         assign ptr_next_seq = ptr_q + 1'b1;
      end else begin : g_add
         assign ptr_next_seq = ptr_q + STEP_V;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) ptr_q <= '0;
      else begin
         unique case (op)
            OP_DIVERT: ptr_q <= async_base;
            OP_RETURN: ptr_q <= saved_ptr;
            OP_START:  ptr_q <= start_ptr;
            OP_ADV:    ptr_q <= ptr_next_seq;
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/asl_seq.sv
module asl_seq
   import asl_pkg::*;
#(
   parameter int PTR_W    = 16,
   parameter int ADV_STEP = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             host_req,
   input  logic [PTR_W-1:0] async_base,
   input  logic             msg_done,
   input  logic             ret_dec,
   input  logic             start_dec,
   input  logic [PTR_W-1:0] start_ptr,
   input  logic             ptr_adv,
   input  logic             list_end,
   output logic [PTR_W-1:0] list_ptr,
   output logic             busy,
   output logic             diverted,
   output logic             pending,
   output logic             start_en,
   output logic             async_en,
   output logic             ret_err
);
   initial begin
      assert (PTR_W >= 2 && PTR_W <= 32)
         else $error("asl_seq: PTR_W out of range");
      assert (ADV_STEP >= 1 && ADV_STEP < (1 << PTR_W))
         else $error("asl_seq: ADV_STEP out of range");
   end

   seq_op_e          op;
   logic [PTR_W-1:0] stack_q;

   asl_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .msg_done(msg_done),
      .ret_dec(ret_dec), .start_dec(start_dec), .ptr_adv(ptr_adv),
      .list_end(list_end), .op(op), .busy_q(busy), .div_q(diverted),
      .pend_q(pending), .err_q(ret_err)
   );

   asl_stack #(.PTR_W(PTR_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push(op == OP_DIVERT),
      .push_val(list_ptr), .top_val(stack_q)
   );

   asl_ptr #(.PTR_W(PTR_W), .ADV_STEP(ADV_STEP)) u_ptr (
      .clk(clk), .rst_n(rst_n), .op(op), .async_base(async_base),
      .saved_ptr(stack_q), .start_ptr(start_ptr), .ptr_q(list_ptr)
   );

   assign start_en = ~diverted;
   assign async_en = ~diverted;
endmodule

// File: rtl/asl_seq_chk.sv
module asl_seq_chk #(
   parameter int PTR_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             host_req,
   input logic [PTR_W-1:0] async_base,
   input logic             msg_done,
   input logic             ret_dec,
   input logic             start_dec,
   input logic             ptr_adv,
   input logic [PTR_W-1:0] list_ptr,
   input logic             busy,
   input logic             diverted,
   input logic             pending,
   input logic             ret_err,
   input logic [PTR_W-1:0] stack_q
);
   p_idle_divert_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !diverted && !pending && host_req)
      |=> (diverted && list_ptr == $past(async_base)));

   p_wait_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !diverted && !msg_done) |=> !diverted);

   p_restore_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (diverted && ret_dec) |=> (!diverted && list_ptr == $past(stack_q)));

   p_hold_div_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (diverted && !ret_dec) |=> diverted);

   p_start_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (diverted && start_dec && !ret_dec && !ptr_adv) |=> $stable(list_ptr));

   p_keep_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (diverted && host_req) |=> pending);

   p_bad_ret_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!diverted && ret_dec) |=> ret_err);

   p_sticky_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err |=> ret_err);
endmodule

bind asl_seq asl_seq_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .host_req(host_req), .async_base(async_base),
   .msg_done(msg_done), .ret_dec(ret_dec), .start_dec(start_dec),
   .ptr_adv(ptr_adv), .list_ptr(list_ptr), .busy(busy),
   .diverted(diverted), .pending(pending), .ret_err(ret_err),
   .stack_q(stack_q)
);

// File: tb/asl_seq_tb.sv
`timescale 1ns/1ps
module asl_seq_tb;
   localparam int W = 16;
   localparam logic [5:0] C_NONE = 6'b000000, C_REQ = 6'b100000,
      C_RET = 6'b010000, C_DONE = 6'b001000, C_START = 6'b000100,
      C_ADV = 6'b000010, C_LEND = 6'b000001;

   function automatic logic [41:0] mkv(input logic [5:0] c, input logic [15:0] d,
                                       input logic [15:0] e, input logic [3:0] f);
      return {c, d, e, f};
   endfunction

   // flags: {busy, diverted, pending, ret_err}
   localparam int NV = 20;
   localparam logic [41:0] VEC [NV] = '{
      mkv(C_START, 16'h0100, 16'h0100, 4'b1000), // R2
      mkv(C_ADV,   16'h0100, 16'h0101, 4'b1000), // R3
      mkv(C_ADV,   16'h0100, 16'h0102, 4'b1000), // R3
      mkv(C_REQ,   16'h0800, 16'h0102, 4'b1010), // R6 pending
      mkv(C_ADV,   16'h0800, 16'h0103, 4'b1010), // R6 no done, no switch
      mkv(C_DONE,  16'h0800, 16'h0800, 4'b1100), // R6 switch
      mkv(C_ADV,   16'h0800, 16'h0801, 4'b1100), // R3 in async list
      mkv(C_START, 16'h0300, 16'h0801, 4'b1100), // R8 start ignored
      mkv(C_REQ,   16'h0900, 16'h0801, 4'b1110), // R9 held
      mkv(C_LEND,  16'h0900, 16'h0801, 4'b1110), // R8 end ignored
      mkv(C_RET,   16'h0900, 16'h0103, 4'b1010), // R7 restore running
      mkv(C_NONE,  16'h0900, 16'h0103, 4'b1010), // R9 waits for done
      mkv(C_DONE,  16'h0900, 16'h0900, 4'b1100), // R9 serviced
      mkv(C_RET,   16'h0900, 16'h0103, 4'b1000), // R7
      mkv(C_LEND,  16'h0900, 16'h0103, 4'b0000), // R4
      mkv(C_ADV,   16'h0900, 16'h0103, 4'b0000), // R3 idle: no effect
      mkv(C_REQ,   16'h0A00, 16'h0A00, 4'b1100), // R5
      mkv(C_RET,   16'h0A00, 16'h0103, 4'b0000), // R7 restore idle
      mkv(C_RET,   16'h0A00, 16'h0103, 4'b0001), // R10
      mkv(C_NONE,  16'h0A00, 16'h0103, 4'b0001)  // R10 sticky
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic host_req = 0, msg_done = 0, ret_dec = 0, start_dec = 0, ptr_adv = 0, list_end = 0;
   logic [W-1:0] async_base = '0, start_ptr = '0;
   logic [W-1:0] list_ptr;
   logic busy, diverted, pending, start_en, async_en, ret_err;
   int total = 0, bad = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   asl_seq #(.PTR_W(W), .ADV_STEP(1)) u_dut (
      .clk(clk), .rst_n(rst_n), .host_req(host_req), .async_base(async_base),
      .msg_done(msg_done), .ret_dec(ret_dec), .start_dec(start_dec),
      .start_ptr(start_ptr), .ptr_adv(ptr_adv), .list_end(list_end),
      .list_ptr(list_ptr), .busy(busy), .diverted(diverted), .pending(pending),
      .start_en(start_en), .async_en(async_en), .ret_err(ret_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive(input logic [5:0] c, input logic [W-1:0] base, input logic [W-1:0] sp);
      @(negedge clk);
      {host_req, ret_dec, msg_done, start_dec, ptr_adv, list_end} = c;
      async_base = base;
      start_ptr  = sp;
      @(posedge clk);
      #1;
   endtask

   task automatic chk_state(input string req, input logic [W-1:0] p, input logic [3:0] f);
      chk({req, " ptr"}, 32'(list_ptr), 32'(p));
      chk({req, " flags"}, {28'd0, busy, diverted, pending, ret_err}, {28'd0, f});
      chk({req, " enables"}, {30'd0, start_en, async_en}, {30'd0, ~f[2], ~f[2]});
   endtask

   initial begin
      #400000;
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk_state("R1 reset", '0, 4'b0000);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      chk_state("R1 after reset", '0, 4'b0000);

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i][41:36], VEC[i][35:20], VEC[i][35:20]);
         chk_state($sformatf("vector %0d R2-R10", i), VEC[i][19:4], VEC[i][3:0]);
      end

      // R11: request and start in the same idle cycle
      drive(C_REQ | C_START, 16'h0C00, 16'h0500);
      chk_state("R11 divert wins", 16'h0C00, 4'b1101);
      drive(C_RET, 16'h0C00, 16'h0500);
      chk_state("R11 return to idle", 16'h0103, 4'b0001);

      // R9: request held during diversion from idle, serviced right after return
      drive(C_REQ, 16'h0D00, 16'h0);
      chk_state("R9 divert", 16'h0D00, 4'b1101);
      drive(C_REQ, 16'h0E00, 16'h0);
      chk_state("R9 held", 16'h0D00, 4'b1111);
      drive(C_RET, 16'h0E00, 16'h0);
      chk_state("R9 returned", 16'h0103, 4'b0011);
      drive(C_NONE, 16'h0E00, 16'h0);
      chk_state("R9 serviced idle", 16'h0E00, 4'b1101);

      // R1: reset in mid run
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      chk_state("R1 mid reset", '0, 4'b0000);
      @(negedge clk); rst_n = 1'b1;

      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule